// File: doc/BRIEF.md
# UART Receive Interrupt and Idle-Timeout Controller

This block sits next to a UART receive FIFO and decides when the receive interrupt is raised. It watches the FIFO occupancy and the arriving-byte strobe, and combines them with plain register fields: FIFO enable, channel number, trigger-level fields, a timeout enable, a timeout length in character times and the frame format. From these it drives three sticky interrupt sources (receive, error, transmit-level), a receive-timeout status flag, the masked pending vector and a single interrupt line.

Incoming bytes arrive as a valid-only stream (`rx_byte_valid`). The serial shifter cannot be stalled, so there is no ready signal and no back-pressure. The block answers in the same cycle with `rx_accept`, which is the write enable for the FIFO or for the single holding register. A byte that finds the FIFO full is dropped, and the error source records the loss. An idle timer counts baud ticks in whole character times. It restarts on every stored byte and raises the receive interrupt when the line stays quiet too long with data left in the FIFO.

Top module: `uart_rxirq_ctrl`

## Requirements
- R1: The receive threshold is (rx_trig_fld + 1) times the channel step. The steps for chan_sel 0, 1, 2, 3 and 4 are 32, 8, 2, 2 and 8. For chan_sel 5 to 7 the threshold is 0.
- R2: With the FIFO enabled, receive source int_src[0] is set at the clock edge where rx_count >= receive threshold. It is also set where rx_count != 0 and tmo_en is 0.
- R3: With the FIFO enabled, the idle timer restarts from zero on every accepted byte while tmo_en is 1. It stops when tmo_en is 0, when the FIFO is disabled, or when the R2 level condition holds. Stopping has priority over a restart.
- R4: One character time is data_bits + stop_bits + 1 baud ticks. The timer expires on the baud tick that ends character number tmo_chars after the restart. A tmo_chars value of 0 expires at the end of the first character.
- R5: When the timer expires, int_src[0] and tmo_flag are set, but only if data_ready is 1 or tmo_force is 1. Otherwise nothing is set and the timer stops.
- R6: A status write (stat_wr) with tmo_wbit equal to 1 clears tmo_flag. A write with tmo_wbit equal to 0 leaves it unchanged. A timeout in the same cycle wins over the clear.
- R7: With the FIFO enabled, a byte is accepted only while rx_count < FIFO_DEPTH. A byte that arrives while the FIFO is full is dropped (rx_accept is 0) and sets error source int_src[1]. With the FIFO disabled, every byte is accepted into the holding register.
- R8: With the FIFO enabled, transmit source int_src[2] is set when tx_count <= tx_trig_fld times the channel step. The +1 does not apply here.
- R9: data_ready is (rx_count != 0) in FIFO mode. In non-FIFO mode it is the holding flag, which is set by an arriving byte and cleared by rx_pop. In non-FIFO mode int_src[0] is set whenever the holding flag is 1.
- R10: The interrupt sources are sticky. Bit 0 is receive, bit 1 is error and bit 2 is transmit. A 1 on int_clr clears the matching bit, and a set condition in the same cycle wins over the clear.
- R11: int_pend equals int_src AND NOT int_mask, with no added delay. irq is the OR of int_pend.
- R12: After reset, all sources, tmo_flag, the holding flag and the timer are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_en | input | 1 | FIFO mode enable |
| chan_sel | input | 3 | Channel number, selects the threshold step |
| rx_trig_fld | input | 2 | Receive trigger-level field |
| tx_trig_fld | input | 2 | Transmit trigger-level field |
| tmo_en | input | 1 | Idle-timeout enable |
| tmo_force | input | 1 | Allow a timeout event with no data present |
| tmo_chars | input | 4 | Timeout length in character times |
| data_bits | input | 4 | Data bits per frame |
| stop_bits | input | 2 | Stop bits per frame |
| baud_tick | input | 1 | One pulse per bit period |
| rx_byte_valid | input | 1 | A received byte is presented this cycle |
| rx_pop | input | 1 | The consumer reads one byte |
| rx_count | input | 7 | Receive FIFO occupancy |
| tx_count | input | 7 | Transmit FIFO occupancy |
| int_mask | input | 3 | Interrupt mask, 1 hides the source |
| int_clr | input | 3 | Per-source clear pulse |
| stat_wr | input | 1 | Status write strobe |
| tmo_wbit | input | 1 | Value written to the timeout flag position |
| rx_accept | output | 1 | Store the presented byte |
| data_ready | output | 1 | Receive data is available |
| int_src | output | 3 | Sticky interrupt sources |
| int_pend | output | 3 | Masked pending sources |
| irq | output | 1 | Interrupt line |
| tmo_flag | output | 1 | Receive-timeout status |

## Verification
A wrong count in the idle timer shows at the ports as tmo_flag and int_src[0] rising a few cycles early or late, or not at all. The reference model flags this on the exact cycle of the expiry edge. A wrong threshold or level decision shows one cycle after rx_count crosses the boundary, as a receive or transmit source that disagrees with the model. A stale holding flag or a missed drop shows in data_ready, rx_accept or int_src[1] on the cycle that follows.

// File: rtl/uart_rxirq_pkg.sv
package uart_rxirq_pkg;
  localparam int unsigned NSRC    = 3;
  localparam int unsigned SRC_RX  = 0;
  localparam int unsigned SRC_ERR = 1;
  localparam int unsigned SRC_TX  = 2;
  localparam int unsigned NCHAN   = 5;
  typedef logic [NSRC-1:0] src_vec_t;
endpackage

// File: rtl/uart_rxirq_thresh.sv
module uart_rxirq_thresh #(
  parameter int unsigned TRIG_W = 2,
  parameter int unsigned CHAN_W = 3,
  parameter int unsigned THR_W  = 8,
  parameter int unsigned STEP0  = 32,
  parameter int unsigned STEP1  = 8,
  parameter int unsigned STEP2  = 2,
  parameter int unsigned STEP3  = 2,
  parameter int unsigned STEP4  = 8
) (
  input  logic [CHAN_W-1:0] chan_sel,
  input  logic [TRIG_W-1:0] rx_fld,
  input  logic [TRIG_W-1:0] tx_fld,
  output logic [THR_W-1:0]  rx_thr,
  output logic [THR_W-1:0]  tx_thr
);
  import uart_rxirq_pkg::*;

  function automatic int unsigned step_for(int unsigned c);
    case (c)
      0:       return STEP0;
      1:       return STEP1;
      2:       return STEP2;
      3:       return STEP3;
      4:       return STEP4;
      default: return 0;
    endcase
  endfunction

  logic [THR_W-1:0] step_tab [NCHAN];
  logic [THR_W-1:0] step;

  generate
    for (genvar c = 0; c < NCHAN; c++) begin : g_step
      assign step_tab[c] = THR_W'(step_for(c));
    end
  endgenerate

  always_comb begin
    step = '0;
    for (int c = 0; c < NCHAN; c++) begin
      if (chan_sel == CHAN_W'(c)) step = step_tab[c];
    end
  end

  assign rx_thr = (THR_W'(rx_fld) + THR_W'(1)) * step;
  assign tx_thr = THR_W'(tx_fld) * step;
endmodule

// File: rtl/uart_rxirq_chartimer.sv
module uart_rxirq_chartimer #(
  parameter int unsigned DBITS_W = 4,
  parameter int unsigned SBITS_W = 2,
  parameter int unsigned TCHR_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run_en,
  input  logic               cancel,
  input  logic               restart,
  input  logic               baud_tick,
  input  logic [DBITS_W-1:0] data_bits,
  input  logic [SBITS_W-1:0] stop_bits,
  input  logic [TCHR_W-1:0]  tmo_chars,
  output logic               fire,
  output logic               running
);
  localparam int unsigned CL_W = ((DBITS_W > SBITS_W) ? DBITS_W : SBITS_W) + 1;

  logic [CL_W-1:0]   bit_cnt;
  logic [CL_W-1:0]   bit_lim;
  logic [TCHR_W-1:0] char_cnt;
  logic              char_end;
  logic              char_last;

  // last bit index of a frame: data + stop + start - 1
  assign bit_lim   = CL_W'(data_bits) + CL_W'(stop_bits);
  assign char_end  = bit_cnt >= bit_lim;
  assign char_last = ({1'b0, char_cnt} + {{TCHR_W{1'b0}}, 1'b1}) >= {1'b0, tmo_chars};
  assign fire      = running && baud_tick && char_end && char_last &&
                     run_en && !cancel && !restart;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running  <= 1'b0;
      bit_cnt  <= '0;
      char_cnt <= '0;
    end else if (!run_en || cancel) begin
      running <= 1'b0;
    end else if (restart) begin
      running  <= 1'b1;
      bit_cnt  <= '0;
      char_cnt <= '0;
    end else if (fire) begin
      running <= 1'b0;
    end else if (running && baud_tick) begin
      if (char_end) begin
        bit_cnt  <= '0;
        char_cnt <= char_cnt + TCHR_W'(1);
      end else begin
        bit_cnt <= bit_cnt + CL_W'(1);
      end
    end
  end

  AST_TMR_STOP_DIS: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en || cancel) |=> !running); // R3
  AST_TMR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !cancel && restart) |=> (running && bit_cnt == '0 && char_cnt == '0)); // R3
  AST_FIRE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !restart) |=> !running); // R4
endmodule

// File: rtl/uart_rxirq_srcregs.sv
module uart_rxirq_srcregs
  import uart_rxirq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  src_vec_t set_v,
  input  src_vec_t clr_v,
  input  src_vec_t mask_v,
  input  logic     tmo_set,
  input  logic     tmo_clr,
  output src_vec_t src_q,
  output src_vec_t pend,
  output logic     irq_o,
  output logic     tmo_q
);
  generate
    for (genvar k = 0; k < NSRC; k++) begin : g_src
      always_ff @(posedge clk) begin
        if (!rst_n)        src_q[k] <= 1'b0;
        else if (set_v[k]) src_q[k] <= 1'b1;
        else if (clr_v[k]) src_q[k] <= 1'b0;
      end

      AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set_v[k] |=> src_q[k]); // R10
      AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_v[k] && !set_v[k]) |=> !src_q[k]); // R10
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)       tmo_q <= 1'b0;
    else if (tmo_set) tmo_q <= 1'b1;
    else if (tmo_clr) tmo_q <= 1'b0;
  end

  assign pend  = src_q & ~mask_v;
  assign irq_o = |pend;

  AST_TMO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_clr && !tmo_set) |=> !tmo_q); // R6
endmodule

// File: rtl/uart_rxirq_ctrl.sv
module uart_rxirq_ctrl
  import uart_rxirq_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 64,
  parameter int unsigned TRIG_W     = 2,
  parameter int unsigned CHAN_W     = 3,
  parameter int unsigned DBITS_W    = 4,
  parameter int unsigned SBITS_W    = 2,
  parameter int unsigned TCHR_W     = 4,
  parameter int unsigned STEP0      = 32,
  parameter int unsigned STEP1      = 8,
  parameter int unsigned STEP2      = 2,
  parameter int unsigned STEP3      = 2,
  parameter int unsigned STEP4      = 8,
  localparam int unsigned CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fifo_en,
  input  logic [CHAN_W-1:0]  chan_sel,
  input  logic [TRIG_W-1:0]  rx_trig_fld,
  input  logic [TRIG_W-1:0]  tx_trig_fld,
  input  logic               tmo_en,
  input  logic               tmo_force,
  input  logic [TCHR_W-1:0]  tmo_chars,
  input  logic [DBITS_W-1:0] data_bits,
  input  logic [SBITS_W-1:0] stop_bits,
  input  logic               baud_tick,
  input  logic               rx_byte_valid,
  input  logic               rx_pop,
  input  logic [CNT_W-1:0]   rx_count,
  input  logic [CNT_W-1:0]   tx_count,
  input  logic [NSRC-1:0]    int_mask,
  input  logic [NSRC-1:0]    int_clr,
  input  logic               stat_wr,
  input  logic               tmo_wbit,
  output logic               rx_accept,
  output logic               data_ready,
  output logic [NSRC-1:0]    int_src,
  output logic [NSRC-1:0]    int_pend,
  output logic               irq,
  output logic               tmo_flag
);
  localparam int unsigned S01      = (STEP0 > STEP1) ? STEP0 : STEP1;
  localparam int unsigned S23      = (STEP2 > STEP3) ? STEP2 : STEP3;
  localparam int unsigned S0123    = (S01 > S23) ? S01 : S23;
  localparam int unsigned STEP_MAX = (S0123 > STEP4) ? S0123 : STEP4;
  localparam int unsigned THR_W    = $clog2((2 ** TRIG_W) * STEP_MAX + 1);
  localparam int unsigned CMP_W    = (CNT_W > THR_W) ? CNT_W : THR_W;

  logic [THR_W-1:0] rx_thr;
  logic [THR_W-1:0] tx_thr;
  logic             fifo_full;
  logic             fifo_store;
  logic             rx_level;
  logic             tx_low;
  logic             hold_q;
  logic             tmr_fire;
  logic             tmr_running;
  logic             tmo_event;
  logic             rx_set;
  src_vec_t         set_v;

  uart_rxirq_thresh #(
    .TRIG_W(TRIG_W), .CHAN_W(CHAN_W), .THR_W(THR_W),
    .STEP0(STEP0), .STEP1(STEP1), .STEP2(STEP2), .STEP3(STEP3), .STEP4(STEP4)
  ) u_thresh (
    .chan_sel (chan_sel),
    .rx_fld   (rx_trig_fld),
    .tx_fld   (tx_trig_fld),
    .rx_thr   (rx_thr),
    .tx_thr   (tx_thr)
  );

  // byte intake: no back-pressure, overflow is dropped
  assign fifo_full  = rx_count >= CNT_W'(FIFO_DEPTH);
  assign fifo_store = rx_byte_valid && fifo_en && !fifo_full;
  assign rx_accept  = rx_byte_valid && (!fifo_en || !fifo_full);

  // level decisions
  assign rx_level = fifo_en &&
                    ((CMP_W'(rx_count) >= CMP_W'(rx_thr)) ||
                     ((rx_count != '0) && !tmo_en));
  assign tx_low   = fifo_en && (CMP_W'(tx_count) <= CMP_W'(tx_thr));

  // single holding register flag for non-FIFO mode
  always_ff @(posedge clk) begin
    if (!rst_n)                          hold_q <= 1'b0;
    else if (!fifo_en && rx_byte_valid)  hold_q <= 1'b1;
    else if (rx_pop)                     hold_q <= 1'b0;
  end

  assign data_ready = fifo_en ? (rx_count != '0) : hold_q;

  uart_rxirq_chartimer #(
    .DBITS_W(DBITS_W), .SBITS_W(SBITS_W), .TCHR_W(TCHR_W)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_en    (fifo_en && tmo_en),
    .cancel    (rx_level),
    .restart   (fifo_store),
    .baud_tick (baud_tick),
    .data_bits (data_bits),
    .stop_bits (stop_bits),
    .tmo_chars (tmo_chars),
    .fire      (tmr_fire),
    .running   (tmr_running)
  );

  assign tmo_event = tmr_fire && (data_ready || tmo_force);
  assign rx_set    = fifo_en ? (rx_level || tmo_event) : hold_q;

  always_comb begin
    set_v          = '0;
    set_v[SRC_RX]  = rx_set;
    set_v[SRC_ERR] = rx_byte_valid && fifo_en && fifo_full;
    set_v[SRC_TX]  = tx_low;
  end

  uart_rxirq_srcregs u_src (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_v   (set_v),
    .clr_v   (int_clr),
    .mask_v  (int_mask),
    .tmo_set (tmo_event),
    .tmo_clr (stat_wr && tmo_wbit),
    .src_q   (int_src),
    .pend    (int_pend),
    .irq_o   (irq),
    .tmo_q   (tmo_flag)
  );

  AST_RX_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && (CMP_W'(rx_count) >= CMP_W'(rx_thr))) |=> int_src[SRC_RX]); // R2
  AST_ERR_ON_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && rx_byte_valid && !rx_accept) |=> int_src[SRC_ERR]); // R7
  AST_TX_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && (CMP_W'(tx_count) <= CMP_W'(tx_thr))) |=> int_src[SRC_TX]); // R8
  AST_TMO_WITH_RX: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_flag) |-> int_src[SRC_RX]); // R5
  AST_HOLD_RX: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en && hold_q) |=> int_src[SRC_RX]); // R9
  AST_LEVEL_STOPS_TMR: assert property (@(posedge clk) disable iff (!rst_n)
    rx_level |=> !tmr_running); // R3
endmodule

// File: tb/tb_uart_rxirq_ctrl.sv
`timescale 1ns/1ps
module tb_uart_rxirq_ctrl;
  localparam int DEPTH = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fifo_en = 1'b0;
  logic [2:0] chan_sel = 3'd0;
  logic [1:0] rx_trig_fld = 2'd0;
  logic [1:0] tx_trig_fld = 2'd0;
  logic       tmo_en = 1'b0;
  logic       tmo_force = 1'b0;
  logic [3:0] tmo_chars = 4'd2;
  logic [3:0] data_bits = 4'd8;
  logic [1:0] stop_bits = 2'd1;
  logic       baud_tick = 1'b0;
  logic       rx_byte_valid = 1'b0;
  logic       rx_pop = 1'b0;
  logic [6:0] rx_count;
  logic [6:0] tx_count = 7'd5;
  logic [2:0] int_mask = 3'b000;
  logic [2:0] int_clr = 3'b000;
  logic       stat_wr = 1'b0;
  logic       tmo_wbit = 1'b0;
  logic       rx_accept, data_ready, irq, tmo_flag;
  logic [2:0] int_src, int_pend;

  int n_chk = 0;
  int n_fail = 0;

  // reference model state
  int         cnt = 0;
  logic [2:0] m_src = 3'b000;
  logic       m_tmo = 1'b0;
  logic       m_hold = 1'b0;
  logic       m_run = 1'b0;
  int         m_bits = 0;
  int         m_chars = 0;
  int         bdiv = 0;

  assign rx_count = 7'(cnt);

  always #2.5 clk = ~clk;

  uart_rxirq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .chan_sel(chan_sel),
    .rx_trig_fld(rx_trig_fld), .tx_trig_fld(tx_trig_fld), .tmo_en(tmo_en),
    .tmo_force(tmo_force), .tmo_chars(tmo_chars), .data_bits(data_bits),
    .stop_bits(stop_bits), .baud_tick(baud_tick), .rx_byte_valid(rx_byte_valid),
    .rx_pop(rx_pop), .rx_count(rx_count), .tx_count(tx_count), .int_mask(int_mask),
    .int_clr(int_clr), .stat_wr(stat_wr), .tmo_wbit(tmo_wbit), .rx_accept(rx_accept),
    .data_ready(data_ready), .int_src(int_src), .int_pend(int_pend), .irq(irq),
    .tmo_flag(tmo_flag)
  );

  function automatic int stepf(int ch);
    case (ch)
      0: return 32;
      1: return 8;
      2: return 2;
      3: return 2;
      4: return 8;
      default: return 0;
    endcase
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  // baud tick: one pulse every four clocks
  always @(posedge clk) begin
    bdiv <= (bdiv == 3) ? 0 : bdiv + 1;
    baud_tick <= (bdiv == 3);
  end

  // behavioural reference model
  always @(posedge clk) begin : model
    int  rthr, tthr, clen;
    bit  lvl, full, store, en, rdy, fire, ok;
    if (!rst_n) begin
      cnt <= 0; m_src <= 3'b000; m_tmo <= 1'b0; m_hold <= 1'b0;
      m_run <= 1'b0; m_bits <= 0; m_chars <= 0;
    end else begin
      rthr  = (int'(rx_trig_fld) + 1) * stepf(int'(chan_sel));
      tthr  = int'(tx_trig_fld) * stepf(int'(chan_sel));
      clen  = int'(data_bits) + int'(stop_bits) + 1;
      full  = cnt >= DEPTH;
      store = rx_byte_valid && fifo_en && !full;
      en    = fifo_en && tmo_en;
      lvl   = fifo_en && (cnt >= rthr || (cnt > 0 && !tmo_en));
      rdy   = fifo_en ? (cnt > 0) : m_hold;
      fire  = m_run && baud_tick && (m_bits >= clen - 1) &&
              (m_chars + 1 >= int'(tmo_chars)) && en && !lvl && !store;
      ok    = fire && (rdy || tmo_force);

      if (!en || lvl) m_run <= 1'b0;
      else if (store) begin m_run <= 1'b1; m_bits <= 0; m_chars <= 0; end
      else if (fire) m_run <= 1'b0;
      else if (m_run && baud_tick) begin
        if (m_bits >= clen - 1) begin m_bits <= 0; m_chars <= m_chars + 1; end
        else m_bits <= m_bits + 1;
      end

      m_src[0] <= (fifo_en ? (lvl || ok) : m_hold) ? 1'b1 : (int_clr[0] ? 1'b0 : m_src[0]);
      m_src[1] <= (fifo_en && rx_byte_valid && full) ? 1'b1 : (int_clr[1] ? 1'b0 : m_src[1]);
      m_src[2] <= (fifo_en && tx_count <= tthr) ? 1'b1 : (int_clr[2] ? 1'b0 : m_src[2]);
      m_tmo    <= ok ? 1'b1 : ((stat_wr && tmo_wbit) ? 1'b0 : m_tmo);
      m_hold   <= (!fifo_en && rx_byte_valid) ? 1'b1 : (rx_pop ? 1'b0 : m_hold);
      cnt      <= cnt + (store ? 1 : 0) - ((rx_pop && fifo_en && cnt > 0) ? 1 : 0);
    end
  end

  // compare against the model on every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      check("R7 rx_accept", int'(rx_accept), int'(rx_byte_valid && (!fifo_en || cnt < DEPTH)));
      check("R9 data_ready", int'(data_ready), int'(fifo_en ? (cnt > 0) : m_hold));
      check("R10 int_src", int'(int_src), int'(m_src));
      check("R5 tmo_flag", int'(tmo_flag), int'(m_tmo));
      check("R11 int_pend", int'(int_pend), int'(m_src & ~int_mask));
      check("R11 irq", int'(irq), int'(|(m_src & ~int_mask)));
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask
  task automatic wait_n(int n);
    repeat (n) tick();
  endtask
  task automatic send(int n);
    rx_byte_valid = 1'b1; repeat (n) tick(); rx_byte_valid = 1'b0;
  endtask
  task automatic pop(int n);
    rx_pop = 1'b1; repeat (n) tick(); rx_pop = 1'b0;
  endtask
  task automatic clr(logic [2:0] v);
    int_clr = v; tick(); int_clr = 3'b000;
  endtask
  task automatic swr(logic b);
    stat_wr = 1'b1; tmo_wbit = b; tick(); stat_wr = 1'b0; tmo_wbit = 1'b0;
  endtask

  initial begin
    wait_n(4);
    rst_n = 1'b1;
    @(negedge clk);
    check("R12 src after reset", int'(int_src), 0);
    check("R12 tmo after reset", int'(tmo_flag), 0);
    check("R12 irq after reset", int'(irq), 0);
    check("R12 ready after reset", int'(data_ready), 0);

    // FIFO mode, channel 0, threshold 32, 2 character timeout
    fifo_en = 1'b1; tmo_en = 1'b1; tmo_chars = 4'd2;
    tick();
    for (int i = 0; i < 3; i++) begin send(1); wait_n(2); end
    wait_n(10);
    @(negedge clk);
    check("R2 below threshold no rx", int'(int_src[0]), 0);
    check("R4 no early timeout", int'(tmo_flag), 0);
    wait_n(150);
    @(negedge clk);
    check("R5 timeout flag", int'(tmo_flag), 1);
    check("R4 timeout raises rx", int'(int_src[0]), 1);

    swr(1'b0);
    @(negedge clk);
    check("R6 write zero keeps flag", int'(tmo_flag), 1);
    swr(1'b1);
    @(negedge clk);
    check("R6 write one clears flag", int'(tmo_flag), 0);

    clr(3'b001);
    @(negedge clk);
    check("R10 clear rx source", int'(int_src[0]), 0);
    tmo_en = 1'b0; tick();
    @(negedge clk);
    check("R2 any data with timeout off", int'(int_src[0]), 1);
    clr(3'b001);
    @(negedge clk);
    check("R10 set wins over clear", int'(int_src[0]), 1);
    tmo_en = 1'b1;
    pop(3);
    clr(3'b001);

    // fill to the level: rx raised, timer cancelled
    send(32); tick();
    @(negedge clk);
    check("R2 level reached", int'(int_src[0]), 1);
    wait_n(150);
    @(negedge clk);
    check("R3 level cancels timeout", int'(tmo_flag), 0);

    send(32);
    rx_byte_valid = 1'b1;
    @(negedge clk);
    check("R7 full drops byte", int'(rx_accept), 0);
    tick(); rx_byte_valid = 1'b0;
    @(negedge clk);
    check("R7 overflow error", int'(int_src[1]), 1);

    int_mask = 3'b111; tick();
    @(negedge clk);
    check("R11 masked irq", int'(irq), 0);
    int_mask = 3'b000; tick();
    @(negedge clk);
    check("R11 unmasked irq", int'(irq), 1);

    tx_trig_fld = 2'd1; tx_count = 7'd40; tick();
    clr(3'b100);
    @(negedge clk);
    check("R8 tx above threshold", int'(int_src[2]), 0);
    tx_count = 7'd32; wait_n(2);
    @(negedge clk);
    check("R8 tx at threshold", int'(int_src[2]), 1);
    tx_count = 7'd40;

    pop(64);
    clr(3'b111);
    chan_sel = 3'd7; wait_n(2);
    @(negedge clk);
    check("R1 unknown channel zero threshold", int'(int_src[0]), 1);

    chan_sel = 3'd2; rx_trig_fld = 2'd1; tmo_chars = 4'd15; tick();
    clr(3'b001);
    send(3); tick();
    @(negedge clk);
    check("R1 channel 2 below 4", int'(int_src[0]), 0);
    send(1); tick();
    @(negedge clk);
    check("R1 channel 2 at 4", int'(int_src[0]), 1);
    pop(4);
    clr(3'b001);

    tmo_chars = 4'd0; data_bits = 4'd5; stop_bits = 2'd2; tick();
    send(1);
    wait_n(60);
    @(negedge clk);
    check("R4 zero length timeout", int'(tmo_flag), 1);
    swr(1'b1); pop(1); clr(3'b001);

    tmo_chars = 4'd2; tmo_force = 1'b0; tick();
    send(1); pop(1);
    wait_n(150);
    @(negedge clk);
    check("R5 no data no timeout", int'(tmo_flag), 0);
    check("R5 no data no rx", int'(int_src[0]), 0);
    tmo_force = 1'b1; tick();
    send(1); pop(1);
    wait_n(150);
    @(negedge clk);
    check("R5 forced timeout", int'(tmo_flag), 1);
    swr(1'b1); clr(3'b001); tmo_force = 1'b0;

    fifo_en = 1'b0; tick();
    clr(3'b111);
    send(1);
    @(negedge clk);
    check("R9 holding ready", int'(data_ready), 1);
    tick();
    @(negedge clk);
    check("R9 holding raises rx", int'(int_src[0]), 1);
    pop(1);
    @(negedge clk);
    check("R9 pop clears ready", int'(data_ready), 0);

    wait_n(5);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual running expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule